// File: doc/BRIEF.md
# HI/LO Register Hazard Monitor

This block watches the stream of retired instructions and flags orderings of accesses to the HI and LO multiply/divide result registers that give unpredictable results. On each cycle it may receive one instruction, marked by a valid strobe and a three-bit class code. The classes are: read of HI, read of LO, write of HI, write of LO, multiply, divide, or anything else. The monitor computes no arithmetic. It keeps an instruction-count clock and, for each of HI and LO, the time of the last read, the last write and the last multiply/divide.

Three hazard rules are checked. The peer-clobber rule covers this case: after a multiply or divide fills both registers, only one of them is overwritten, and the other is then read. The write-after-read rule covers a write to a register that lands fewer than two instructions after a read of that same register. The operation-after-read rule covers a multiply or divide that lands fewer than two instructions after a read of either register. A two-bit mode input selects which rules are active, with three further enable inputs for the configurable mode. Every broken rule produces a one-cycle violation pulse with a reason code. Checks never block the timestamp updates.

Top module: `hilo_hazard_mon`

## Requirements
- R1: After reset `viol_o` is 0, and no instruction is flagged under the write-after-read or operation-after-read rules until a read has actually happened. The instruction clock starts four counts after every stored time.
- R2: The peer-clobber rule is active in every mode. When a read of register X (class 1 = HI, 2 = LO) arrives, it is flagged with reason 1 if all of these hold: the peer's last write is later than the last operation; X's last write is earlier than that operation; and neither exemption of R3 applies.
- R3: The peer-clobber rule is suppressed when a read of X, or a read of its peer, happened strictly after the last operation and strictly before the peer's last write.
- R4: The write-after-read rule applies when enabled. A write (class 3 = HI, 4 = LO) is flagged with reason 2 when the last read of the same register, plus 3, exceeds the current instruction count. A distance of three instructions is not flagged.
- R5: The operation-after-read rule applies when enabled. A multiply (class 5) or divide (class 6) is flagged with reason 3 when the last read of HI or of LO, plus 3, exceeds the current count.
- R6: In mode 1 the write-after-read rule is off and the operation-after-read rule applies to divides only.
- R7: In mode 3 only the peer-clobber rule is active. Timestamps keep being recorded.
- R8: In mode 0 all rules are active. In mode 2, `chk_mt_i`, `chk_mul_i` and `chk_div_i` separately enable the write-after-read check, the multiply check and the divide check.
- R9: A violation appears on `viol_o`/`viol_rsn_o` one clock after the instruction is presented, for one cycle. Cycles with `instr_valid_i` low do not advance the instruction count.
- R10: Class 0 and 7 are ordinary instructions. Reason 0 means no violation. All timestamps update even when a violation is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | One retired instruction this cycle |
| instr_cls_i | input | 3 | Instruction class code |
| arch_mode_i | input | 2 | Rule-set selector (0 legacy, 1 vendor, 2 configurable, 3 modern) |
| chk_mt_i | input | 1 | Mode 2: enable the write-after-read check |
| chk_mul_i | input | 1 | Mode 2: enable the operation-after-read check for multiplies |
| chk_div_i | input | 1 | Mode 2: enable the operation-after-read check for divides |
| viol_o | output | 1 | Violation pulse |
| viol_rsn_o | output | 2 | Reason: 1 peer clobber, 2 write after read, 3 operation after read |

## Verification
Every verdict is due exactly one clock after its instruction is presented, because only the output register lies between the inputs and the ports. Each driven cycle, including bubble cycles, pushes one expectation stamped with the cycle it was issued in. The monitor pops an expectation only once the clock counter has passed that stamp, and compares it at the falling edge. The scripted stream runs through every mode. It places reads at distances two and three from later writes and operations, and it inserts bubbles inside a window to show that they do not count.

// File: rtl/hilo_mon_pkg.sv
package hilo_mon_pkg;

    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_MFHI  = 3'd1,
        CLS_MFLO  = 3'd2,
        CLS_MTHI  = 3'd3,
        CLS_MTLO  = 3'd4,
        CLS_MUL   = 3'd5,
        CLS_DIV   = 3'd6,
        CLS_SPARE = 3'd7
    } instr_cls_e;

    typedef enum logic [1:0] {
        MODE_LEGACY  = 2'd0,
        MODE_VENDOR  = 2'd1,
        MODE_TUNABLE = 2'd2,
        MODE_MODERN  = 2'd3
    } arch_mode_e;

    typedef enum logic [1:0] {
        RSN_NONE    = 2'd0,
        RSN_PEER    = 2'd1,
        RSN_MT_NEAR = 2'd2,
        RSN_OP_NEAR = 2'd3
    } viol_rsn_e;

    // Register indices into the timestamp banks
    localparam int NUM_REGS = 2;
    localparam int IDX_HI   = 0;
    localparam int IDX_LO   = 1;

    // A read within this many counts of a later write/operation is hazardous
    localparam int HAZ_WIN  = 3;

    typedef struct packed {
        logic rd;      // move from HI/LO
        logic wr;      // move to HI/LO
        logic mul;
        logic div;
        logic sel_lo;  // target register of rd/wr: 0 = HI, 1 = LO
    } hilo_evt_t;

    typedef struct packed {
        logic chk_mt;
        logic chk_mul;
        logic chk_div;
    } rule_en_t;

    function automatic hilo_evt_t decode_cls(input logic [2:0] cls);
        hilo_evt_t e;
        e = '0;
        unique case (instr_cls_e'(cls))
            CLS_MFHI: e.rd = 1'b1;
            CLS_MFLO: begin e.rd = 1'b1; e.sel_lo = 1'b1; end
            CLS_MTHI: e.wr = 1'b1;
            CLS_MTLO: begin e.wr = 1'b1; e.sel_lo = 1'b1; end
            CLS_MUL:  e.mul = 1'b1;
            CLS_DIV:  e.div = 1'b1;
            default:  e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/hilo_rule_sel.sv
module hilo_rule_sel
    import hilo_mon_pkg::*;
(
    input  logic [1:0] arch_mode_i,
    input  logic       chk_mt_i,
    input  logic       chk_mul_i,
    input  logic       chk_div_i,
    output rule_en_t   en_o
);

    always_comb begin
        en_o = '0;
        unique case (arch_mode_e'(arch_mode_i))
            MODE_LEGACY: begin
                en_o.chk_mt  = 1'b1;
                en_o.chk_mul = 1'b1;
                en_o.chk_div = 1'b1;
            end
            MODE_VENDOR: begin
                en_o.chk_div = 1'b1;
            end
            MODE_TUNABLE: begin
                en_o.chk_mt  = chk_mt_i;
                en_o.chk_mul = chk_mul_i;
                en_o.chk_div = chk_div_i;
            end
            default: en_o = '0;
        endcase
    end

endmodule

// File: rtl/hilo_ts_bank.sv
module hilo_ts_bank
    import hilo_mon_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               valid_i,
    input  hilo_evt_t                          ev_i,
    output logic [TS_W-1:0]                    now_o,
    output logic [NUM_REGS-1:0][TS_W-1:0]      rd_ts_o,
    output logic [NUM_REGS-1:0][TS_W-1:0]      wr_ts_o,
    output logic [NUM_REGS-1:0][TS_W-1:0]      op_ts_o
);

    // Clock starts one count beyond the hazard window so reset-time stamps are harmless
    localparam logic [TS_W-1:0] NOW_START = TS_W'(HAZ_WIN + 1);

    logic [TS_W-1:0] now_q;

    always_ff @(posedge clk) begin
        if (rst)          now_q <= NOW_START;
        else if (valid_i) now_q <= now_q + 1'b1;
    end

    assign now_o = now_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic SEL = 1'(g);
        logic [TS_W-1:0] rd_q, wr_q, op_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
                wr_q <= '0;
                op_q <= '0;
            end else if (valid_i) begin
                if (ev_i.rd && ev_i.sel_lo == SEL) rd_q <= now_q;
                if (ev_i.wr && ev_i.sel_lo == SEL) wr_q <= now_q;
                if (ev_i.mul || ev_i.div)          op_q <= now_q;
            end
        end

        assign rd_ts_o[g] = rd_q;
        assign wr_ts_o[g] = wr_q;
        assign op_ts_o[g] = op_q;
    end

    // R9: bubbles leave the instruction clock untouched
    a_r9_bubble_holds_clock: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(now_o));

    // R9: every accepted instruction moves the clock
    a_r9_instr_moves_clock: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> !$stable(now_o));

    // R10: an operation stamps both registers with the same time
    a_r10_op_stamps_both: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (ev_i.mul || ev_i.div)) |=> (op_ts_o[IDX_HI] == op_ts_o[IDX_LO]));

endmodule

// File: rtl/hilo_rule_eval.sv
module hilo_rule_eval
    import hilo_mon_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic                          valid_i,
    input  hilo_evt_t                     ev_i,
    input  rule_en_t                      en_i,
    input  logic [TS_W-1:0]               now_i,
    input  logic [NUM_REGS-1:0][TS_W-1:0] rd_ts_i,
    input  logic [NUM_REGS-1:0][TS_W-1:0] wr_ts_i,
    input  logic [NUM_REGS-1:0][TS_W-1:0] op_ts_i,
    output logic                          hit_o,
    output viol_rsn_e                     rsn_o
);

    localparam int EXT_W = TS_W + 1;

    function automatic logic too_close(input logic [TS_W-1:0] rd_t,
                                       input logic [TS_W-1:0] cur_t);
        return (EXT_W'(rd_t) + EXT_W'(HAZ_WIN)) > EXT_W'(cur_t);
    endfunction

    logic            self_idx, peer_idx;
    logic [TS_W-1:0] s_op, s_wr, s_rd, p_wr, p_rd;
    logic            self_gap, peer_gap, clobber;
    logic            near_self, near_any, op_checked;

    always_comb begin
        self_idx = ev_i.sel_lo;
        peer_idx = ~ev_i.sel_lo;
        s_op = op_ts_i[self_idx];
        s_wr = wr_ts_i[self_idx];
        s_rd = rd_ts_i[self_idx];
        p_wr = wr_ts_i[peer_idx];
        p_rd = rd_ts_i[peer_idx];

        // exemptions: a read landed between the operation and the peer's write
        self_gap = (s_rd > s_op) && (s_rd < p_wr);
        peer_gap = (p_rd > s_op) && (p_rd < p_wr);
        clobber  = (p_wr > s_op) && (s_wr < s_op) && !self_gap && !peer_gap;

        near_self  = too_close(s_rd, now_i);
        near_any   = too_close(rd_ts_i[IDX_HI], now_i) || too_close(rd_ts_i[IDX_LO], now_i);
        op_checked = (ev_i.mul && en_i.chk_mul) || (ev_i.div && en_i.chk_div);
    end

    always_comb begin
        hit_o = 1'b0;
        rsn_o = RSN_NONE;
        if (valid_i) begin
            if (ev_i.rd) begin
                if (clobber) begin
                    hit_o = 1'b1;
                    rsn_o = RSN_PEER;
                end
            end else if (ev_i.wr) begin
                if (en_i.chk_mt && near_self) begin
                    hit_o = 1'b1;
                    rsn_o = RSN_MT_NEAR;
                end
            end else if (op_checked && near_any) begin
                hit_o = 1'b1;
                rsn_o = RSN_OP_NEAR;
            end
        end
    end

endmodule

// File: rtl/hilo_hazard_mon.sv
module hilo_hazard_mon
    import hilo_mon_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_valid_i,
    input  logic [2:0] instr_cls_i,
    input  logic [1:0] arch_mode_i,
    input  logic       chk_mt_i,
    input  logic       chk_mul_i,
    input  logic       chk_div_i,
    output logic       viol_o,
    output logic [1:0] viol_rsn_o
);

    hilo_evt_t                     ev;
    rule_en_t                      en;
    logic [TS_W-1:0]               now;
    logic [NUM_REGS-1:0][TS_W-1:0] rd_ts, wr_ts, op_ts;
    logic                          hit;
    viol_rsn_e                     rsn;

    assign ev = decode_cls(instr_cls_i);

    hilo_rule_sel u_sel (
        .arch_mode_i (arch_mode_i),
        .chk_mt_i    (chk_mt_i),
        .chk_mul_i   (chk_mul_i),
        .chk_div_i   (chk_div_i),
        .en_o        (en)
    );

    hilo_ts_bank #(.TS_W(TS_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .valid_i (instr_valid_i),
        .ev_i    (ev),
        .now_o   (now),
        .rd_ts_o (rd_ts),
        .wr_ts_o (wr_ts),
        .op_ts_o (op_ts)
    );

    hilo_rule_eval #(.TS_W(TS_W)) u_eval (
        .valid_i (instr_valid_i),
        .ev_i    (ev),
        .en_i    (en),
        .now_i   (now),
        .rd_ts_i (rd_ts),
        .wr_ts_i (wr_ts),
        .op_ts_i (op_ts),
        .hit_o   (hit),
        .rsn_o   (rsn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_o     <= 1'b0;
            viol_rsn_o <= RSN_NONE;
        end else begin
            viol_o     <= hit;
            viol_rsn_o <= rsn;
        end
    end

    // R9: a pulse is only ever caused by an instruction one clock earlier
    a_r9_pulse_after_instr: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> $past(instr_valid_i));

    // R10: a pulse always carries a real reason
    a_r10_reason_present: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (viol_rsn_o != RSN_NONE));

    // R7: modern mode reports only the peer-clobber rule
    a_r7_modern_peer_only: assert property (@(posedge clk) disable iff (rst)
        (viol_o && $past(arch_mode_i) == MODE_MODERN) |-> (viol_rsn_o == RSN_PEER));

    // R6: vendor mode never reports write-after-read, nor a multiply
    a_r6_vendor_subset: assert property (@(posedge clk) disable iff (rst)
        (viol_o && $past(arch_mode_i) == MODE_VENDOR)
            |-> (viol_rsn_o != RSN_MT_NEAR && $past(instr_cls_i) != CLS_MUL));

    // R5: operation-after-read reasons come from multiplies or divides only
    a_r5_op_reason_source: assert property (@(posedge clk) disable iff (rst)
        (viol_o && viol_rsn_o == RSN_OP_NEAR)
            |-> ($past(instr_cls_i) == CLS_MUL || $past(instr_cls_i) == CLS_DIV));

    // R2: peer-clobber reasons come from reads only
    a_r2_peer_reason_source: assert property (@(posedge clk) disable iff (rst)
        (viol_o && viol_rsn_o == RSN_PEER)
            |-> ($past(instr_cls_i) == CLS_MFHI || $past(instr_cls_i) == CLS_MFLO));

endmodule

// File: tb/hilo_hazard_mon_tb_top.sv
module hilo_hazard_mon_tb_top;

    localparam logic [2:0] C_OT = 3'd0, C_RH = 3'd1, C_RL = 3'd2, C_WH = 3'd3,
                           C_WL = 3'd4, C_MU = 3'd5, C_DV = 3'd6;
    localparam logic [1:0] E0 = 2'd0, E_PEER = 2'd1, E_WR = 2'd2, E_OP = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       instr_valid_i = 1'b0;
    logic [2:0] instr_cls_i = '0;
    logic [1:0] arch_mode_i = '0;
    logic       chk_mt_i = 1'b0, chk_mul_i = 1'b0, chk_div_i = 1'b0;
    logic       viol_o;
    logic [1:0] viol_rsn_o;

    int unsigned cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [1:0] md_next = 2'd0;
    logic [2:0] cfg_next = 3'b000; // {mt, mul, div}

    typedef struct {
        int unsigned cyc;
        logic [1:0]  exp;
        string       req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) cyc <= cyc + 1;

    hilo_hazard_mon dut_i (
        .clk           (clk),
        .rst           (rst),
        .instr_valid_i (instr_valid_i),
        .instr_cls_i   (instr_cls_i),
        .arch_mode_i   (arch_mode_i),
        .chk_mt_i      (chk_mt_i),
        .chk_mul_i     (chk_mul_i),
        .chk_div_i     (chk_div_i),
        .viol_o        (viol_o),
        .viol_rsn_o    (viol_rsn_o)
    );

    task automatic drive(input logic v, input logic [2:0] cls,
                         input logic [1:0] exp, input string req);
        exp_item_t it;
        @(negedge clk);
        instr_valid_i = v;
        instr_cls_i   = cls;
        arch_mode_i   = md_next;
        chk_mt_i      = cfg_next[2];
        chk_mul_i     = cfg_next[1];
        chk_div_i     = cfg_next[0];
        it.cyc = cyc;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic issue(input logic [2:0] cls, input logic [1:0] exp, input string req);
        drive(1'b1, cls, exp, req);
    endtask

    task automatic bubble(input string req);
        drive(1'b0, 3'd0, E0, req);
    endtask

    task automatic others(input int n);
        for (int i = 0; i < n; i++) issue(C_OT, E0, "R10");
    endtask

    // Monitor: compares each expectation once its result is registered
    initial begin
        exp_item_t it;
        logic [1:0] act;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
                it = sb_q.pop_front();
                act = viol_o ? viol_rsn_o : 2'd0;
                checks++;
                if (viol_o !== (it.exp != 2'd0) || act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: viol=%0b reason=%0d expected reason=%0d (issued cycle %0d)",
                             it.req, viol_o, viol_rsn_o, it.exp, it.cyc);
                end
            end
        end
    end

    function automatic void summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (viol_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: viol after reset=%0b expected=0", viol_o);
        end

        // Legacy mode: all rules
        md_next = 2'd0;
        issue(C_WH, E0, "R1");       // t4: no earlier read
        issue(C_RL, E0, "R1");       // t5
        issue(C_MU, E_OP, "R5");     // t6: read of LO at t5
        others(3);                   // t7..t9
        issue(C_WH, E0, "R4");       // t10: HI never read
        issue(C_RL, E_PEER, "R2");   // t11: HI overwritten after op t6
        issue(C_WL, E_WR, "R4");     // t12: LO read at t11
        others(2);                   // t13,t14
        issue(C_RH, E0, "R2");       // t15: HI's own write after op
        others(2);                   // t16,t17
        issue(C_WH, E0, "R4");       // t18: distance 3, allowed
        issue(C_RH, E0, "R2");       // t19
        issue(C_OT, E0, "R10");      // t20
        issue(C_WH, E_WR, "R4");     // t21: distance 2
        issue(C_DV, E0, "R5");       // t22: distance 3 from read t19
        issue(C_RL, E0, "R2");       // t23
        bubble("R9");
        bubble("R9");
        issue(C_DV, E_OP, "R9");     // t24: bubbles do not widen the gap
        others(3);                   // t25..t27
        issue(C_MU, E0, "R5");       // t28
        issue(C_RH, E0, "R3");       // t29
        others(2);                   // t30,t31
        issue(C_WL, E0, "R4");       // t32
        issue(C_RH, E0, "R3");       // t33: own read t29 sits in the gap
        others(2);                   // t34,t35
        issue(C_MU, E0, "R5");       // t36: distance 3 from read t33
        issue(C_RL, E0, "R3");       // t37
        others(2);                   // t38,t39
        issue(C_WL, E0, "R4");       // t40
        issue(C_RH, E0, "R3");       // t41: peer read t37 sits in the gap
        others(3);                   // t42..t44

        // Vendor mode
        md_next = 2'd1;
        issue(C_RH, E0, "R6");       // t45
        issue(C_WH, E0, "R6");       // t46: write-after-read off
        issue(C_MU, E0, "R6");       // t47: multiply exempt
        issue(C_RH, E0, "R6");       // t48
        issue(C_DV, E_OP, "R6");     // t49: divide still checked
        others(3);                   // t50..t52

        // Modern mode
        md_next = 2'd3;
        issue(C_RL, E0, "R7");       // t53
        issue(C_WL, E0, "R7");       // t54
        issue(C_MU, E0, "R7");       // t55
        issue(C_DV, E0, "R7");       // t56
        issue(C_WL, E0, "R7");       // t57
        issue(C_RH, E_PEER, "R7");   // t58: peer-clobber still live
        others(3);                   // t59..t61

        // Configurable mode: write check only
        md_next = 2'd2;
        cfg_next = 3'b100;
        issue(C_RH, E_PEER, "R8");   // t62: LO write t57 after op t56
        issue(C_WH, E_WR, "R8");     // t63
        issue(C_MU, E0, "R8");       // t64
        issue(C_RL, E0, "R8");       // t65
        issue(C_DV, E0, "R8");       // t66
        // Configurable mode: operation checks only
        cfg_next = 3'b011;
        issue(C_RL, E0, "R8");       // t67
        issue(C_WL, E0, "R8");       // t68
        issue(C_MU, E_OP, "R8");     // t69
        issue(C_RH, E0, "R8");       // t70
        issue(C_DV, E_OP, "R8");     // t71
        issue(3'd7, E0, "R10");      // spare class acts as ordinary
        others(2);
        bubble("R9");
        bubble("R9");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d expectations left unchecked, expected 0", sb_q.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule